// File: doc/BRIEF.md
# Conversion Trigger and Interrupt Control

This block is one control register on a small host bus, together with the logic it steers in a data-acquisition front end. It decides which event produces the A/D conversion start pulse. The choices are a software strobe alone, a rising edge on an external digital input, or a pulse from an internal pacer counter. It also latches a conversion-done event into an interrupt request. That request appears on exactly one of eight host interrupt lines, chosen by a level field. Lines 0 and 1 are never driven.

The same register enables a DMA request, which is raised when a conversion completes and held until the host acknowledges it. Software controls all of this by writing one byte at a fixed bus offset and can read the byte back. A separate clear strobe retires a pending interrupt. Counter programming, the converter and the host DMA engine are outside the block.

Top module: `acq_trig_ctrl`

## Requirements
- R1: The register answers only at offset 9. A write there stores the byte with bit 3 forced to 0, and a read there returns the stored byte. Reads at any other offset return 0, and writes at any other offset leave the register unchanged.
- R2: After reset the register reads 0, no interrupt line is asserted, the DMA request is low, and only the software strobe can start a conversion.
- R3: While the interrupt enable (bit 7) is 0, every interrupt line stays low.
- R4: With the interrupt enabled and a request pending, a level field (bits 6:4) value n from 2 to 7 asserts line n alone.
- R5: Level values 0 and 1 assert no interrupt line.
- R6: With DMA enable (bit 2) set, a conversion-done raises the DMA request on the next cycle. The request holds until DMA acknowledge. With bit 2 clear, the request is low.
- R7: When trigger-select bit 1 (bit 1) is 0, only the software strobe starts a conversion. Trigger-select bit 0 (bit 0), the pacer pulse and the external input then have no effect.
- R8: Trigger-select code 10 (bits 1:0) turns each rising edge of the external input into exactly one single-cycle start pulse. The external input passes through a two-flop synchronizer and an edge stage first.
- R9: Trigger-select code 11 starts a conversion in the same cycle as each pacer pulse.
- R10: The software start strobe starts a conversion in every trigger mode.
- R11: A pending interrupt is set by conversion-done and held until the clear strobe. If the level field changes while a request is pending, the request moves to the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register offset on the host bus |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (0 when offset does not match) |
| swStart | input | 1 | Software conversion start strobe |
| extTrig | input | 1 | Asynchronous external digital trigger |
| pacerPulse | input | 1 | Pulse from internal pacer counter |
| convDone | input | 1 | Conversion complete pulse |
| irqClear | input | 1 | Clears the pending interrupt |
| dmaAck | input | 1 | Host DMA acknowledge |
| convStart | output | 1 | Conversion start pulse |
| irqReq | output | 8 | One-hot host interrupt lines |
| dmaReq | output | 1 | DMA request |

## Verification
The bench builds the block with its default parameters: a 4-bit offset, register offset 9, a two-stage synchronizer and a lowest usable line of 2. A 4-bit offset lets random addresses reach both the register and fifteen other offsets, so misdecoded writes and reads show up. A 3-bit level field covers every line, including the two dead codes. The two synchronizer stages fix the latency of the external edge that the bench model follows flop for flop.

// File: rtl/trigctl_pkg.sv
package trigctl_pkg;
  localparam int DATA_W  = 8;
  localparam int LEVEL_W = 3;

  localparam int BIT_IRQ_EN = 7;
  localparam int BIT_LVL_LO = 4;
  localparam int BIT_DMA_EN = 2;
  localparam int BIT_TSEL1  = 1;
  localparam int BIT_TSEL0  = 0;
  localparam logic [DATA_W-1:0] REG_MASK = 8'hF7;

  typedef enum logic [1:0] {
    TRIG_SW    = 2'd0,
    TRIG_EXT   = 2'd2,
    TRIG_PACER = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic               irqEn;
    logic [LEVEL_W-1:0] level;
    logic               dmaEn;
    trig_mode_e         trigMode;
    logic               irqClr;
  } ctrl_strobes_t;
endpackage

// File: rtl/trigctl_regs.sv
module trigctl_regs
  import trigctl_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int REG_OFFSET = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic                irqClear,
  output ctrl_strobes_t       ctrlOut
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

  logic [DATA_W-1:0] ctrlQ;
  logic              hit;

  assign hit = (busAddr == HIT_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN)                ctrlQ <= '0;
    else if (busWrEn && hit)  ctrlQ <= busWrData & REG_MASK;
  end

  always_comb begin
    ctrlOut.irqEn  = ctrlQ[BIT_IRQ_EN];
    ctrlOut.level  = ctrlQ[BIT_LVL_LO +: LEVEL_W];
    ctrlOut.dmaEn  = ctrlQ[BIT_DMA_EN];
    ctrlOut.irqClr = irqClear;
    if (!ctrlQ[BIT_TSEL1])     ctrlOut.trigMode = TRIG_SW;
    else if (ctrlQ[BIT_TSEL0]) ctrlOut.trigMode = TRIG_PACER;
    else                       ctrlOut.trigMode = TRIG_EXT;
    busRdData = hit ? ctrlQ : '0;
  end
endmodule

// File: rtl/trigctl_datapath.sv
module trigctl_datapath
  import trigctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LINE    = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_strobes_t            ctrlIn,
  input  logic                     swStart,
  input  logic                     extTrig,
  input  logic                     pacerPulse,
  input  logic                     convDone,
  input  logic                     dmaAck,
  output logic                     convStart,
  output logic [(1<<LEVEL_W)-1:0]  irqReq,
  output logic                     dmaReq
);
  localparam int IRQ_LINES = 1 << LEVEL_W;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   extRise;
  logic                   pendQ;
  logic                   dmaQ;

  // Synchronizer chain, one flop per stage.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= 1'b0;
      else       syncQ[s] <= (s == 0) ? extTrig : syncQ[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign extRise = syncQ[SYNC_STAGES-1] & ~prevQ;

  always_comb begin
    unique case (ctrlIn.trigMode)
      TRIG_EXT:   convStart = swStart | extRise;
      TRIG_PACER: convStart = swStart | pacerPulse;
      default:    convStart = swStart;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      dmaQ  <= 1'b0;
    end else begin
      if (ctrlIn.irqClr)                      pendQ <= 1'b0;
      else if (convDone && ctrlIn.irqEn)      pendQ <= 1'b1;
      if (dmaAck)                             dmaQ  <= 1'b0;
      else if (convDone && ctrlIn.dmaEn)      dmaQ  <= 1'b1;
    end
  end

  assign dmaReq = dmaQ & ctrlIn.dmaEn;

  for (genvar i = 0; i < IRQ_LINES; i++) begin : g_line
    if (i < MIN_LINE) begin : g_dead
      assign irqReq[i] = 1'b0;
    end else begin : g_live
      assign irqReq[i] = pendQ && ctrlIn.irqEn && (ctrlIn.level == LEVEL_W'(i));
    end
  end
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import trigctl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int REG_OFFSET  = 9,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LINE    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [7:0]         busWrData,
  output logic [7:0]         busRdData,
  input  logic               swStart,
  input  logic               extTrig,
  input  logic               pacerPulse,
  input  logic               convDone,
  input  logic               irqClear,
  input  logic               dmaAck,
  output logic               convStart,
  output logic [7:0]         irqReq,
  output logic               dmaReq
);
  ctrl_strobes_t ctrlBus;

  trigctl_regs #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqClear(irqClear),
    .ctrlOut(ctrlBus)
  );

  trigctl_datapath #(.SYNC_STAGES(SYNC_STAGES), .MIN_LINE(MIN_LINE)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlBus), .swStart(swStart),
    .extTrig(extTrig), .pacerPulse(pacerPulse), .convDone(convDone),
    .dmaAck(dmaAck), .convStart(convStart), .irqReq(irqReq), .dmaReq(dmaReq)
  );
endmodule

// File: rtl/trigctl_checker.sv
module trigctl_checker
  import trigctl_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input ctrl_strobes_t ctrl,
  input logic          swStart,
  input logic          dmaAck,
  input logic          convStart,
  input logic [7:0]    irqReq,
  input logic          dmaReq
);
  assert_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.irqEn |-> irqReq == 8'h00);

  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqReq));

  assert_dead_lines_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.level < 3'd2 |-> irqReq == 8'h00);

  assert_dma_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && !dmaAck |=> dmaReq || !ctrl.dmaEn);

  assert_sw_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.trigMode == TRIG_SW && !swStart |-> !convStart);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.trigMode == TRIG_EXT && !swStart && convStart
      |=> !convStart || swStart || ctrl.trigMode != TRIG_EXT);

  assert_sw_any_mode_R10: assert property (@(posedge clk) disable iff (!rstN)
    swStart |-> convStart);

  assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqReq != 8'h00 && !ctrl.irqClr
      |=> irqReq == $past(irqReq) || ctrl != $past(ctrl));
endmodule

bind acq_trig_ctrl trigctl_checker u_chk (
  .clk(clk), .rstN(rstN), .ctrl(ctrlBus), .swStart(swStart), .dmaAck(dmaAck),
  .convStart(convStart), .irqReq(irqReq), .dmaReq(dmaReq)
);

// File: tb/sim_acq_trig_ctrl.sv
module sim_acq_trig_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       swStart = 1'b0, extTrig = 1'b0, pacerPulse = 1'b0;
  logic       convDone = 1'b0, irqClear = 1'b0, dmaAck = 1'b0;
  logic       convStart, dmaReq;
  logic [7:0] irqReq;

  int nChecks = 0, nFails = 0;
  logic [7:0] mReg = '0;
  logic       mPend = 0, mDma = 0;
  logic [2:0] mExt = '0;
  int         startCount;

  always #5 clk = ~clk;

  acq_trig_ctrl u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .swStart(swStart),
    .extTrig(extTrig), .pacerPulse(pacerPulse), .convDone(convDone),
    .irqClear(irqClear), .dmaAck(dmaAck), .convStart(convStart),
    .irqReq(irqReq), .dmaReq(dmaReq)
  );

  function automatic logic [7:0] expIrq(logic [7:0] r, logic p);
    if (p && r[7] && r[6:4] >= 3'd2) return 8'h01 << r[6:4];
    return 8'h00;
  endfunction

  function automatic logic expStart(logic [7:0] r, logic sw, logic pc, logic rise);
    if (sw) return 1'b1;
    if (r[1] && r[0]) return pc;
    if (r[1]) return rise;
    return 1'b0;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    busWrEn = 0; swStart = 0; pacerPulse = 0; convDone = 0; irqClear = 0; dmaAck = 0;
  endtask

  // One clock: combinational checks before the edge, model update, registered checks after.
  task automatic tick();
    #2;
    chk(mReg[1] ? (mReg[0] ? "R9 R10 start" : "R8 R10 start") : "R7 R10 start",
        {7'b0, convStart}, {7'b0, expStart(mReg, swStart, pacerPulse, mExt[1] & ~mExt[2])});
    if (convStart) startCount++;
    chk("R1 read", busRdData, (busAddr == 4'd9) ? mReg : 8'h00);
    @(posedge clk);
    mPend = irqClear ? 1'b0 : ((convDone && mReg[7]) ? 1'b1 : mPend);
    mDma  = dmaAck ? 1'b0 : ((convDone && mReg[2]) ? 1'b1 : mDma);
    mExt  = {mExt[1], mExt[0], extTrig};
    if (busWrEn && busAddr == 4'd9) mReg = busWrData & 8'hF7;
    #1;
    chk("R3 R4 R5 R11 irq", irqReq, expIrq(mReg, mPend));
    chk("R6 dma", {7'b0, dmaReq}, {7'b0, mDma & mReg[2]});
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1; tick(); busWrEn = 0;
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1601));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R2 reset state
    busAddr = 4'd9; #1;
    chk("R2 reset read", busRdData, 8'h00);
    chk("R2 reset irq", irqReq, 8'h00);
    chk("R2 reset dma", {7'b0, dmaReq}, 8'h00);
    pacerPulse = 1; #1;
    chk("R2 reset start", {7'b0, convStart}, 8'h00);
    idle();

    // R1 masking and decode
    wr(4'd9, 8'hFF); tick();
    chk("R1 bit3 masked", busRdData, 8'hF7);
    wr(4'd3, 8'h00); busAddr = 4'd9; tick();
    chk("R1 foreign write ignored", busRdData, 8'hF7);
    busAddr = 4'd3; tick();

    // R7 code 01 ignores pacer and external edge
    wr(4'd9, 8'h01);
    pacerPulse = 1; tick(); pacerPulse = 0;
    startCount = 0; extTrig = 1; repeat (5) tick(); extTrig = 0; repeat (3) tick();
    chk("R7 no start from ext/pacer", 8'(startCount), 8'd0);

    // R8 one pulse per rising edge
    wr(4'd9, 8'h02); repeat (3) tick();
    startCount = 0; extTrig = 1; repeat (6) tick();
    chk("R8 single pulse per edge", 8'(startCount), 8'd1);
    extTrig = 0; repeat (3) tick();

    // R9 pacer, R10 software in pacer mode
    wr(4'd9, 8'h03); pacerPulse = 1; tick(); pacerPulse = 0;
    swStart = 1; tick(); swStart = 0;

    // R4, R11 hold and move, R5 dead level
    wr(4'd9, 8'hD0); convDone = 1; tick(); convDone = 0;
    chk("R4 line 5", irqReq, 8'h20);
    repeat (3) tick();
    wr(4'd9, 8'hB0);
    chk("R11 moved to line 3", irqReq, 8'h08);
    wr(4'd9, 8'h90);
    chk("R5 level 1 silent", irqReq, 8'h00);
    wr(4'd9, 8'hF0);
    chk("R4 line 7", irqReq, 8'h80);
    wr(4'd9, 8'h70);
    chk("R3 disabled", irqReq, 8'h00);
    irqClear = 1; tick(); irqClear = 0;

    // R6 DMA
    wr(4'd9, 8'h04); convDone = 1; tick(); convDone = 0; repeat (2) tick();
    chk("R6 dma held", {7'b0, dmaReq}, 8'h01);
    dmaAck = 1; tick(); dmaAck = 0;
    chk("R6 dma acked", {7'b0, dmaReq}, 8'h00);

    // Constrained random
    for (int n = 0; n < 600; n++) begin
      busAddr    = ($urandom % 3 == 0) ? 4'd9 : 4'($urandom);
      busWrEn    = ($urandom % 5 == 0);
      busWrData  = 8'($urandom);
      swStart    = ($urandom % 8 == 0);
      pacerPulse = ($urandom % 3 == 0);
      convDone   = ($urandom % 5 == 0);
      irqClear   = ($urandom % 9 == 0);
      dmaAck     = ($urandom % 7 == 0);
      if ($urandom % 4 == 0) extTrig = ~extTrig;
      tick();
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule